// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of an 8-bit controller whose low address byte and data share one port. It runs directly on the oscillator clock and splits time into machine cycles of twelve clocks: six states of two phases each. In every cycle it raises the address-latch strobe twice. When code is fetched from external memory, it also pulls the active-low program-store read strobe low twice per cycle. It also chooses the byte driven on the high-address port, and reports whether the low address/data port should float.

An external data-memory access is requested by a level sampled on the last clock of a machine cycle. The following cycle then becomes a data cycle. In a data cycle the second address-latch pulse and both program-store reads are dropped, and the high-address port carries either the upper byte of a 16-bit data address or the port's own register, depending on the addressing width. An ALE-disable control bit can park the address-latch strobe high. In that case it still pulses in data cycles and code-table cycles, and the bit has no effect during external execution. The idle and power-down modes force fixed strobe levels. The reset pin is filtered, so a pulse must last two full machine cycles before it takes effect. All control and status pins are plain levels; no data stream passes through the block.

Top module: `bus_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clocks numbered slot 0 to 11, where slot = 2*state + phase. ALE is high in slots 0, 1, 6 and 7 and low in all other slots (pattern 12'h0C3, bit i = slot i). With internal execution, PSEN_n stays high.
- R2: With external execution and no data cycle, PSEN_n is low in slots 4, 5, 10 and 11 and high elsewhere (pattern 12'h3CF).
- R3: xreq_i and tbl_i are sampled on the clock edge that ends slot 11, and they govern the next cycle. In a data cycle ALE is high only in slots 0 and 1 (12'h003), and PSEN_n stays high for all 12 slots.
- R4: The high-address port carries dhi_i in a data cycle with xwide_i=1, p2_reg_i in a data cycle with xwide_i=0, pc_hi_i in a non-data cycle with external execution, and p2_reg_i in a non-data cycle with internal execution.
- R5: With ale_off_i=1, internal execution, and neither a data cycle nor a table cycle, ALE stays high for the whole cycle.
- R6: With ale_off_i=1 and internal execution, a table cycle shows pattern 12'h0C3 and a data cycle shows pattern 12'h003.
- R7: With external execution, ale_off_i has no effect on ALE.
- R8: In idle, ALE and PSEN_n are both high. The high-address port carries pc_hi_i with external execution and p2_reg_i otherwise. lo_float_o equals ext_exec_i.
- R9: In power-down, ALE and PSEN_n are both low, the high-address port carries p2_reg_i, and lo_float_o equals ext_exec_i. Outside idle and power-down, lo_float_o is 0.
- R10: A reset-pin pulse held high for fewer than 24 consecutive clock edges has no effect on the strobe sequence.
- R11: After 24 consecutive high edges the reset is recognised. While it is recognised, ALE is low and PSEN_n is high. The clock period after the first edge that sees the pin low is slot 0 of a cycle, and that cycle is a non-data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin_i | input | 1 | Raw reset pin, active high, filtered |
| ext_exec_i | input | 1 | Code is fetched from external program memory |
| xreq_i | input | 1 | External data access requested for the next cycle |
| xwide_i | input | 1 | Requested access uses a 16-bit address |
| tbl_i | input | 1 | Code-table read in the next cycle |
| ale_off_i | input | 1 | ALE-disable control bit |
| idle_i | input | 1 | Idle mode active |
| pdown_i | input | 1 | Power-down mode active |
| pc_hi_i | input | 8 | Upper byte of the fetch address |
| dhi_i | input | 8 | Upper byte of a 16-bit data address |
| p2_reg_i | input | 8 | Contents of the high port's own register |
| ale_o | output | 1 | Address-latch strobe |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| hi_addr_o | output | 8 | Value on the high-address port |
| lo_float_o | output | 1 | Low address/data port released to float |

## Verification
Two functions can land in the same cycle: data-cycle suppression and the ALE-disable gate. The bench provokes this by applying an ALE-disable setting together with a 16-bit data request during internal execution. The expected result is that the gate yields, so the first ALE pulse still appears, the second is missing, and the high port shows the data byte. A second case pairs the reset filter with a running sequence. A 23-edge pulse must leave the slot pattern intact, while a 24-edge pulse must force inactive strobes and restart the cycle at slot 0. Both outcomes are judged slot by slot at the pins.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    HI_PORT = 2'd0,
    HI_PC   = 2'd1,
    HI_DATA = 2'd2
  } hi_sel_e;
endpackage

// File: rtl/bss_rst_filter.sv
module bss_rst_filter #(
  parameter int RST_CLKS = 24,
  parameter int CW       = 5
) (
  input  logic clk,
  input  logic pin_i,
  output logic rst_o
);
  localparam logic [CW-1:0] LIMIT = CW'(RST_CLKS);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!pin_i)              run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign rst_o = (run_q == LIMIT);

  AST_RST_DROP: assert property (@(posedge clk) !pin_i |=> !rst_o);           // R10
  AST_RST_HOLD: assert property (@(posedge clk) (rst_o && pin_i) |=> rst_o);  // R11
endmodule

// File: rtl/bss_seq.sv
module bss_seq #(
  parameter int N_STATES = 6,
  parameter int N_PHASES = 2,
  parameter int SW       = 3,
  parameter int PW       = 1
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          xreq_i,
  input  logic          xwide_i,
  input  logic          tbl_i,
  output logic [SW-1:0] st_o,
  output logic          dcyc_o,
  output logic          dwide_o,
  output logic          tbl_o
);
  localparam logic [SW-1:0] ST_LAST = SW'(N_STATES - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(N_PHASES - 1);

  logic [PW-1:0] ph_q;
  logic          edge_end;

  assign edge_end = (st_o == ST_LAST) && (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      st_o    <= '0;
      ph_q    <= '0;
      dcyc_o  <= 1'b0;
      dwide_o <= 1'b0;
      tbl_o   <= 1'b0;
    end else begin
      if (ph_q == PH_LAST) begin
        ph_q <= '0;
        st_o <= (st_o == ST_LAST) ? '0 : st_o + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
      if (edge_end) begin
        dcyc_o  <= xreq_i;
        dwide_o <= xwide_i;
        tbl_o   <= tbl_i;
      end
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst_i)
    (ph_q != PH_LAST) |=> $stable(st_o));                                   // R1
  AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (rst_i)
    edge_end |=> (st_o == '0 && ph_q == '0));                                // R1
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst_i)
    !edge_end |=> ($stable(dcyc_o) && $stable(tbl_o)));                      // R3
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst_i |=> (st_o == '0 && ph_q == '0 && !dcyc_o));                        // R11
endmodule

// File: rtl/bss_strobe.sv
module bss_strobe
  import bss_pkg::*;
#(
  parameter int N_STATES = 6,
  parameter int SW       = 3,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic [SW-1:0] st_i,
  input  logic          dcyc_i,
  input  logic          dwide_i,
  input  logic          tbl_i,
  input  logic          ext_i,
  input  logic          ale_off_i,
  input  logic          idle_i,
  input  logic          pdown_i,
  input  logic [AW-1:0] pc_hi_i,
  input  logic [AW-1:0] dhi_i,
  input  logic [AW-1:0] p2_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic [AW-1:0] hi_o,
  output logic          float_o
);
  localparam logic [SW-1:0] ALE_2ND = SW'(N_STATES / 2);
  localparam logic [SW-1:0] RD_1ST  = SW'(N_STATES / 2 - 1);
  localparam logic [SW-1:0] RD_2ND  = SW'(N_STATES - 1);

  logic    ale_slot, rd_slot, gate_off;
  hi_sel_e sel;

  assign ale_slot = (st_i == '0) || ((st_i == ALE_2ND) && !dcyc_i);
  assign rd_slot  = ext_i && !dcyc_i && ((st_i == RD_1ST) || (st_i == RD_2ND));
  assign gate_off = ale_off_i && !ext_i && !dcyc_i && !tbl_i;

  always_comb begin
    sel      = ext_i ? HI_PC : HI_PORT;
    ale_o    = gate_off ? 1'b1 : ale_slot;
    psen_n_o = !rd_slot;
    if (rst_i) begin
      ale_o    = 1'b0;
      psen_n_o = 1'b1;
      sel      = HI_PORT;
    end else if (pdown_i) begin
      ale_o    = 1'b0;
      psen_n_o = 1'b0;
      sel      = HI_PORT;
    end else if (idle_i) begin
      ale_o    = 1'b1;
      psen_n_o = 1'b1;
    end else if (dcyc_i) begin
      sel = dwide_i ? HI_DATA : HI_PORT;
    end
  end

  always_comb begin
    unique case (sel)
      HI_PC:   hi_o = pc_hi_i;
      HI_DATA: hi_o = dhi_i;
      default: hi_o = p2_i;
    endcase
  end

  assign float_o = (idle_i || pdown_i) && ext_i && !rst_i;

  AST_DATA_NO_READ: assert property (@(posedge clk) disable iff (rst_i)
    (!psen_n_o && !pdown_i) |-> (!dcyc_i && ext_i));                         // R3
  AST_PD_LEVELS: assert property (@(posedge clk) disable iff (rst_i)
    pdown_i |-> (!ale_o && !psen_n_o));                                       // R9
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst_i)
    (idle_i && !pdown_i) |-> (ale_o && psen_n_o));                            // R8
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq #(
  parameter int N_STATES = 6,
  parameter int N_PHASES = 2,
  parameter int RST_MCYC = 2,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_pin_i,
  input  logic          ext_exec_i,
  input  logic          xreq_i,
  input  logic          xwide_i,
  input  logic          tbl_i,
  input  logic          ale_off_i,
  input  logic          idle_i,
  input  logic          pdown_i,
  input  logic [AW-1:0] pc_hi_i,
  input  logic [AW-1:0] dhi_i,
  input  logic [AW-1:0] p2_reg_i,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic [AW-1:0] hi_addr_o,
  output logic          lo_float_o
);
  localparam int CYC      = N_STATES * N_PHASES;
  localparam int RST_CLKS = RST_MCYC * CYC;
  localparam int CW       = $clog2(RST_CLKS + 1);
  localparam int SW       = (N_STATES > 1) ? $clog2(N_STATES) : 1;
  localparam int PW       = (N_PHASES > 1) ? $clog2(N_PHASES) : 1;

  logic          rst_int;
  logic [SW-1:0] st;
  logic          dcyc, dwide, tblc;

  bss_rst_filter #(.RST_CLKS(RST_CLKS), .CW(CW)) u_filt (
    .clk(clk), .pin_i(rst_pin_i), .rst_o(rst_int)
  );

  bss_seq #(.N_STATES(N_STATES), .N_PHASES(N_PHASES), .SW(SW), .PW(PW)) u_seq (
    .clk(clk), .rst_i(rst_int), .xreq_i(xreq_i), .xwide_i(xwide_i),
    .tbl_i(tbl_i), .st_o(st), .dcyc_o(dcyc), .dwide_o(dwide), .tbl_o(tblc)
  );

  bss_strobe #(.N_STATES(N_STATES), .SW(SW), .AW(AW)) u_strb (
    .clk(clk), .rst_i(rst_int), .st_i(st), .dcyc_i(dcyc), .dwide_i(dwide),
    .tbl_i(tblc), .ext_i(ext_exec_i), .ale_off_i(ale_off_i), .idle_i(idle_i),
    .pdown_i(pdown_i), .pc_hi_i(pc_hi_i), .dhi_i(dhi_i), .p2_i(p2_reg_i),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .hi_o(hi_addr_o), .float_o(lo_float_o)
  );

  AST_EXT_IGNORES_OFF: assert property (@(posedge clk) disable iff (rst_int)
    (ext_exec_i && !idle_i && !pdown_i && st == '0) |-> ale_o);               // R7
endmodule

// File: tb/test_bus_strobe_seq.sv
`timescale 1ns/1ps
module test_bus_strobe_seq;
  typedef struct packed {
    logic        ext, aoff, xreq, xwide, tbl, idl, pd;
    logic [11:0] ale, psn;
    logic [1:0]  hsel;
    logic        flt;
  } vec_t;

  localparam int NV = 15;
  localparam logic [11:0] NORM_ALE = 12'h0C3;
  localparam logic [11:0] NORM_PSN = 12'h3CF;
  localparam logic [7:0]  P2V = 8'h5A, PCV = 8'hC3, DHV = 8'h96;

  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h0C3,12'h3CF,2'd1,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,12'h003,12'hFFF,2'd2,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,12'h003,12'hFFF,2'd0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h0C3,12'h3CF,2'd1,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h0C3,12'hFFF,2'd0,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,12'h003,12'hFFF,2'd2,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'hFFF,12'hFFF,2'd0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,12'h0C3,12'hFFF,2'd0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,12'h003,12'hFFF,2'd2,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,12'h0C3,12'h3CF,2'd1,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,12'hFFF,12'hFFF,2'd1,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,12'hFFF,12'hFFF,2'd0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,12'h000,12'h000,2'd0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,12'h000,12'h000,2'd0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,12'h0C3,12'h3CF,2'd1,1'b0}
  };

  logic clk = 1'b0;
  logic rst_pin = 1'b1;
  logic ext = 1'b1, xreq = 1'b0, xwide = 1'b0, tbl = 1'b0, aoff = 1'b0;
  logic idl = 1'b0, pd = 1'b0;
  logic [7:0] pc_hi = PCV, dhi = DHV, p2 = P2V;
  logic ale, psen_n, flt;
  logic [7:0] hi;
  int n_tests = 0, n_fail = 0, sl = 0;

  always #2 clk = ~clk;

  bus_strobe_seq i_bus_strobe_seq (
    .clk(clk), .rst_pin_i(rst_pin), .ext_exec_i(ext), .xreq_i(xreq),
    .xwide_i(xwide), .tbl_i(tbl), .ale_off_i(aoff), .idle_i(idl),
    .pdown_i(pd), .pc_hi_i(pc_hi), .dhi_i(dhi), .p2_reg_i(p2),
    .ale_o(ale), .psen_n_o(psen_n), .hi_addr_o(hi), .lo_float_o(flt)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    ext = v.ext; aoff = v.aoff; xreq = v.xreq; xwide = v.xwide;
    tbl = v.tbl; idl = v.idl; pd = v.pd;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.pd)                      return "R9";
    if (v.idl)                     return "R8";
    if (v.aoff && v.ext)           return "R7";
    if (v.aoff && (v.xreq || v.tbl)) return "R6";
    if (v.aoff)                    return "R5";
    if (v.xreq)                    return "R3";
    if (v.ext)                     return "R2";
    return "R1";
  endfunction

  // one slot of the undisturbed external-execution pattern (R1, R2)
  task automatic tick(input string tag);
    @(negedge clk);
    check(tag, {7'd0, ale}, {7'd0, NORM_ALE[sl]});
    check(tag, {7'd0, psen_n}, {7'd0, NORM_PSN[sl]});
    sl = (sl + 1) % 12;
  endtask

  initial begin
    repeat (26) @(negedge clk);
    check("R11 reset ale", {7'd0, ale}, 8'd0);
    check("R11 reset psen", {7'd0, psen_n}, 8'd1);
    rst_pin = 1'b0;
    sl = 0;
    for (int s = 0; s < 12; s++) tick("R11 first cycle");
    apply(VECS[0]);
    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < 12; s++) begin
        @(negedge clk);
        check(tag_of(VECS[v]), {7'd0, ale}, {7'd0, VECS[v].ale[s]});
        check(tag_of(VECS[v]), {7'd0, psen_n}, {7'd0, VECS[v].psn[s]});
        if (s == 0) begin
          check("R4 high port", hi,
                (VECS[v].hsel == 2'd1) ? PCV : (VECS[v].hsel == 2'd2) ? DHV : P2V);
          check({tag_of(VECS[v]), " float"}, {7'd0, flt}, {7'd0, VECS[v].flt});
        end
        if (s == 11 && v != NV - 1) apply(VECS[v+1]);
      end
    end
    // short reset pulse: 23 high edges, sequence continues (R10)
    sl = 0;
    for (int k = 0; k < 23; k++) begin
      tick("R10 short pulse");
      if (k == 0) rst_pin = 1'b1;
    end
    tick("R10 short pulse");
    rst_pin = 1'b0;
    for (int k = 0; k < 12; k++) tick("R10 after pulse");
    // full reset: 24 high edges, inactive strobes, restart at slot 0 (R11)
    for (int k = 0; k < 24; k++) begin
      tick("R11 before recognition");
      if (k == 0) rst_pin = 1'b1;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 held ale", {7'd0, ale}, 8'd0);
      check("R11 held psen", {7'd0, psen_n}, 8'd1);
    end
    rst_pin = 1'b0;
    sl = 0;
    for (int k = 0; k < 12; k++) tick("R11 restart");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule